// File: doc/BRIEF.md
# Interlaced Scan Fetch Address Generator

This block generates the memory fetch stream for a 200-line, 16-colour-palette bitmap display. It can also generate a 400-line interlaced picture built from two fields. Each time the timing generator signals a new displayed line, the block does three things in order. It requests that line's control byte. It waits for the byte to return and uses its low nibble to pick one of sixteen 32-byte palettes. It then requests the whole palette followed by the line's 160 pixel bytes. Every request leaves on a valid/ready port as a bank number, a 16-bit offset and a kind tag, so a memory arbiter can serve it and send the result to the pixel pipeline.

The source bank comes from a page-select setting that is captured at each frame strobe. The aux setting reads every field from bank 0xE1 and the main setting from bank 0xE0. The split setting reads odd fields from 0xE1 and even fields from 0xE0. In split mode each field therefore uses its own control bytes and palettes. The field flips at every frame strobe while interlace is enabled and is held at odd otherwise, so split without interlace shows only bank 0xE1. Pixel decoding, palette lookup and sync generation belong to other blocks.

Top module: `scan_fetch_gen`

## Requirements
- R1: After reset no fetch is valid, the page setting is aux (bank 0xE1), the field is odd and the next line strobe fetches line 0.
- R2: Each accepted line issues, in this order: one control fetch (kind 0) at 0x9D00 + line, then 32 palette fetches (kind 1), then 160 pixel fetches (kind 2), each group at ascending offsets. After that fetch_valid falls.
- R3: The palette fetches start at 0x9E00 + 32 * ctrl_rdata[3:0], using the byte returned with ctrl_rvalid. Bits 7:4 of that byte have no effect.
- R4: Pixel fetches for line n start at 0x2000 + 160 * n. The line number is 0 after a frame strobe and goes up by one for each completed line.
- R5: page_sel encodings are 0 = aux (bank 0xE1), 1 = main (bank 0xE0), 2 = split (bank 0xE1 in the odd field, bank 0xE0 in the even field) and 3 = treated as aux. Every fetch of one line uses the same bank.
- R6: At a frame strobe the field flips if ilace_en is 1 at that strobe. Otherwise the field is set to odd.
- R7: page_sel and ilace_en are sampled only at a frame strobe. Changing them mid-frame does not alter the bank of later lines in that frame.
- R8: While fetch_valid is high and fetch_ready is low, fetch_bank, fetch_addr and fetch_kind hold their values.
- R9: A line strobe that arrives while a line is in progress, or after 200 lines have completed in the current frame, is ignored.
- R10: A frame strobe stops any line in progress. fetch_valid is low in the next cycle and the next line strobe fetches line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | One-cycle pulse: start the next displayed line |
| frame_strobe | input | 1 | One-cycle pulse: frame boundary, latches settings |
| page_sel | input | 2 | Bank setting: 0 aux, 1 main, 2 split, 3 aux |
| ilace_en | input | 1 | Interlace enable |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_bank | output | 8 | Bank of the request |
| fetch_addr | output | 16 | Offset within the bank |
| fetch_kind | output | 2 | 0 control byte, 1 palette, 2 pixel |
| ctrl_rvalid | input | 1 | Control byte returned |
| ctrl_rdata | input | 8 | Returned control byte |

## Verification
The bench runs split mode through several frames with interlace on and off. A design that toggled the field while interlace was off, or that did not tie bank choice to field parity, would read the wrong bank on alternate frames. It returns control bytes whose high nibble is set, so a palette offset built from the full byte would fall outside the palette region. It then runs all 200 lines of a frame to check that the last pixel fetch ends at 0x9CFF and that a 201st strobe does nothing. It also drives strobes into a busy line, changes settings mid-frame and issues a frame strobe mid-line. A design that counted the extra strobe, applied settings at once or kept fetching after the frame strobe would produce a wrong line number, a wrong bank or a stray request.

// File: rtl/scan_fetch_pkg.sv
package scan_fetch_pkg;

   // kind tag presented with every request
   typedef enum logic [1:0] {
      FK_CTRL = 2'd0,
      FK_PAL  = 2'd1,
      FK_PIX  = 2'd2
   } fetch_kind_e;

   // page setting codes (code 3 falls back to aux)
   localparam logic [1:0] PS_AUX   = 2'd0;
   localparam logic [1:0] PS_MAIN  = 2'd1;
   localparam logic [1:0] PS_SPLIT = 2'd2;

   // per-line sequencer states
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_CTRL = 3'd1,
      S_WAIT = 3'd2,
      S_PAL  = 3'd3,
      S_PIX  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/scan_field_ctl.sv
module scan_field_ctl
   import scan_fetch_pkg::*;
#(
   parameter int          BANK_W        = 8,
   parameter logic [7:0]  AUX_BANK      = 8'hE1,
   parameter logic [7:0]  MAIN_BANK     = 8'hE0,
   parameter bit          ODD_FROM_AUX  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_strobe,
   input  logic [1:0]        page_sel,
   input  logic              ilace_en,
   output logic [BANK_W-1:0] cur_bank,
   output logic              field_odd
);

   localparam logic [BANK_W-1:0] AUX_B  = BANK_W'(AUX_BANK);
   localparam logic [BANK_W-1:0] MAIN_B = BANK_W'(MAIN_BANK);

   if (BANK_W < 1 || BANK_W > 8) begin : g_bad_bank_w
      $error("scan_field_ctl: BANK_W must be 1..8");
   end

   logic [1:0] sel_q;
   logic       ilace_q;
   logic [BANK_W-1:0] odd_bank;
   logic [BANK_W-1:0] even_bank;

   // settings only move at the frame boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= PS_AUX;
         ilace_q   <= 1'b0;
         field_odd <= 1'b1;
      end else if (frame_strobe) begin
         sel_q     <= page_sel;
         ilace_q   <= ilace_en;
         field_odd <= ilace_en ? ~field_odd : 1'b1;
      end
   end

   // split-mode field to bank mapping variant
   if (ODD_FROM_AUX) begin : g_odd_aux
      assign odd_bank  = AUX_B;
      assign even_bank = MAIN_B;
   end else begin : g_odd_main
      assign odd_bank  = MAIN_B;
      assign even_bank = AUX_B;
   end

   always_comb begin
      case (sel_q)
         PS_MAIN:  cur_bank = MAIN_B;
         PS_SPLIT: cur_bank = field_odd ? odd_bank : even_bank;
         default:  cur_bank = AUX_B;
      endcase
   end

   // R6
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ilace_q |-> field_odd);

   // R6
   field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_strobe && ilace_en) |=> (field_odd != $past(field_odd)));

   // R7
   cfg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_strobe |=> ($stable(sel_q) && $stable(ilace_q)));

endmodule

// File: rtl/scan_line_seq.sv
module scan_line_seq
   import scan_fetch_pkg::*;
#(
   parameter int LINES      = 200,
   parameter int LINE_BYTES = 160,
   parameter int PAL_BYTES  = 32,
   parameter int PAL_SEL_W  = 4,
   parameter int DATA_W     = 8,
   localparam int LINE_W    = $clog2(LINES + 1),
   localparam int MAX_RUN   = (LINE_BYTES > PAL_BYTES) ? LINE_BYTES : PAL_BYTES,
   localparam int CNT_W     = $clog2(MAX_RUN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_strobe,
   input  logic                 frame_strobe,
   input  logic                 fetch_ready,
   input  logic                 ctrl_rvalid,
   input  logic [DATA_W-1:0]    ctrl_rdata,
   output logic                 req_valid,
   output logic [1:0]           req_kind,
   output logic [LINE_W-1:0]    line_num,
   output logic [PAL_SEL_W-1:0] pal_idx,
   output logic [CNT_W-1:0]     run_cnt,
   output logic                 line_done
);

   localparam logic [CNT_W-1:0]  PAL_LAST  = CNT_W'(PAL_BYTES - 1);
   localparam logic [CNT_W-1:0]  PIX_LAST  = CNT_W'(LINE_BYTES - 1);
   localparam logic [LINE_W-1:0] LINE_LIM  = LINE_W'(LINES);

   if (PAL_SEL_W > DATA_W) begin : g_bad_sel_w
      $error("scan_line_seq: palette select wider than control byte");
   end
   if (LINES < 1 || LINE_BYTES < 2 || PAL_BYTES < 2) begin : g_bad_sizes
      $error("scan_line_seq: line and palette runs must be at least 2");
   end

   seq_state_e            state_q;
   logic [LINE_W-1:0]     line_q;
   logic [CNT_W-1:0]      cnt_q;
   logic [PAL_SEL_W-1:0]  idx_q;
   logic                  accept_line;

   assign accept_line = line_strobe && (line_q < LINE_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         line_q  <= '0;
         cnt_q   <= '0;
         idx_q   <= '0;
      end else if (frame_strobe) begin
         state_q <= S_IDLE;
         line_q  <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (accept_line) state_q <= S_CTRL;
            end
            S_CTRL: begin
               if (fetch_ready) state_q <= S_WAIT;
            end
            S_WAIT: begin
               if (ctrl_rvalid) begin
                  idx_q   <= ctrl_rdata[PAL_SEL_W-1:0];
                  cnt_q   <= '0;
                  state_q <= S_PAL;
               end
            end
            S_PAL: begin
               if (fetch_ready) begin
                  if (cnt_q == PAL_LAST) begin
                     cnt_q   <= '0;
                     state_q <= S_PIX;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            S_PIX: begin
               if (fetch_ready) begin
                  if (cnt_q == PIX_LAST) begin
                     cnt_q   <= '0;
                     line_q  <= line_q + 1'b1;
                     state_q <= S_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_valid = 1'b0;
      req_kind  = FK_CTRL;
      case (state_q)
         S_CTRL: begin req_valid = 1'b1; req_kind = FK_CTRL; end
         S_PAL:  begin req_valid = 1'b1; req_kind = FK_PAL;  end
         S_PIX:  begin req_valid = 1'b1; req_kind = FK_PIX;  end
         default: ;
      endcase
   end

   assign line_num  = line_q;
   assign pal_idx   = idx_q;
   assign run_cnt   = cnt_q;
   assign line_done = (state_q == S_PIX) && fetch_ready && (cnt_q == PIX_LAST)
                      && !frame_strobe;

   // R9
   line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_q <= LINE_LIM);

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CTRL && !frame_strobe) |=> $stable(line_q));

   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_strobe |=> (state_q == S_IDLE && line_q == '0));

   // R2
   pix_after_pal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_PIX) |-> ($past(state_q) == S_PAL || $past(state_q) == S_PIX));

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
   import scan_fetch_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          LINE_BYTES = 160,
   parameter int          PAL_BYTES  = 32,
   parameter int          PAL_SEL_W  = 4,
   parameter int          LINE_W     = 8,
   parameter int          CNT_W      = 8,
   parameter logic [15:0] PIX_BASE   = 16'h2000,
   parameter logic [15:0] CTRL_BASE  = 16'h9D00,
   parameter logic [15:0] PAL_BASE   = 16'h9E00,
   parameter bit          PIX_MUL    = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_strobe,
   input  logic                 line_done,
   input  logic [1:0]           req_kind,
   input  logic [LINE_W-1:0]    line_num,
   input  logic [PAL_SEL_W-1:0] pal_idx,
   input  logic [CNT_W-1:0]     run_cnt,
   output logic [ADDR_W-1:0]    addr
);

   localparam logic [ADDR_W-1:0] PIX_B  = ADDR_W'(PIX_BASE);
   localparam logic [ADDR_W-1:0] CTRL_B = ADDR_W'(CTRL_BASE);
   localparam logic [ADDR_W-1:0] PAL_B  = ADDR_W'(PAL_BASE);
   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LINE_BYTES);
   localparam logic [ADDR_W-1:0] PSIZE  = ADDR_W'(PAL_BYTES);

   logic [ADDR_W-1:0] line_base;
   logic [ADDR_W-1:0] pal_start;

   // pixel base: multiplier or running accumulator
   if (PIX_MUL) begin : g_pix_mul
      assign line_base = PIX_B + ADDR_W'(line_num) * STRIDE;
   end else begin : g_pix_acc
      logic [ADDR_W-1:0] acc_q;
      always_ff @(posedge clk) begin
         if (!rst_n || frame_strobe) begin
            acc_q <= PIX_B;
         end else if (line_done) begin
            acc_q <= acc_q + STRIDE;
         end
      end
      assign line_base = acc_q;
   end

   assign pal_start = PAL_B + ADDR_W'(pal_idx) * PSIZE;

   always_comb begin
      case (req_kind)
         FK_PAL:  addr = pal_start + ADDR_W'(run_cnt);
         FK_PIX:  addr = line_base + ADDR_W'(run_cnt);
         default: addr = CTRL_B + ADDR_W'(line_num);
      endcase
   end

endmodule

// File: rtl/scan_fetch_gen.sv
module scan_fetch_gen
   import scan_fetch_pkg::*;
#(
   parameter int          LINES      = 200,
   parameter int          LINE_BYTES = 160,
   parameter int          PAL_BYTES  = 32,
   parameter int          PAL_SEL_W  = 4,
   parameter int          ADDR_W     = 16,
   parameter int          BANK_W     = 8,
   parameter int          DATA_W     = 8,
   parameter logic [15:0] PIX_BASE   = 16'h2000,
   parameter logic [15:0] CTRL_BASE  = 16'h9D00,
   parameter logic [15:0] PAL_BASE   = 16'h9E00,
   parameter logic [7:0]  AUX_BANK   = 8'hE1,
   parameter logic [7:0]  MAIN_BANK  = 8'hE0,
   parameter bit          PIX_MUL    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_strobe,
   input  logic              frame_strobe,
   input  logic [1:0]        page_sel,
   input  logic              ilace_en,
   output logic              fetch_valid,
   input  logic              fetch_ready,
   output logic [BANK_W-1:0] fetch_bank,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [1:0]        fetch_kind,
   input  logic              ctrl_rvalid,
   input  logic [DATA_W-1:0] ctrl_rdata
);

   localparam int LINE_W   = $clog2(LINES + 1);
   localparam int MAX_RUN  = (LINE_BYTES > PAL_BYTES) ? LINE_BYTES : PAL_BYTES;
   localparam int CNT_W    = $clog2(MAX_RUN);
   localparam int PIX_END  = int'(PIX_BASE) + LINES * LINE_BYTES;
   localparam int PAL_END  = int'(PAL_BASE) + (2 ** PAL_SEL_W) * PAL_BYTES;

   // region layout sanity at elaboration
   if (PIX_END > int'(CTRL_BASE)) begin : g_bad_pix_region
      $error("scan_fetch_gen: pixel region overlaps control bytes");
   end
   if (int'(CTRL_BASE) + LINES > int'(PAL_BASE)) begin : g_bad_ctrl_region
      $error("scan_fetch_gen: control region overlaps palettes");
   end
   if (PAL_END > 2 ** ADDR_W) begin : g_bad_pal_region
      $error("scan_fetch_gen: palette region exceeds address space");
   end

   logic [LINE_W-1:0]    line_num;
   logic [PAL_SEL_W-1:0] pal_idx;
   logic [CNT_W-1:0]     run_cnt;
   logic                 line_done;
   logic                 field_odd;

   scan_field_ctl #(
      .BANK_W    (BANK_W),
      .AUX_BANK  (AUX_BANK),
      .MAIN_BANK (MAIN_BANK),
      .ODD_FROM_AUX(1'b1)
   ) field_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (frame_strobe),
      .page_sel     (page_sel),
      .ilace_en     (ilace_en),
      .cur_bank     (fetch_bank),
      .field_odd    (field_odd)
   );

   scan_line_seq #(
      .LINES      (LINES),
      .LINE_BYTES (LINE_BYTES),
      .PAL_BYTES  (PAL_BYTES),
      .PAL_SEL_W  (PAL_SEL_W),
      .DATA_W     (DATA_W)
   ) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_strobe  (line_strobe),
      .frame_strobe (frame_strobe),
      .fetch_ready  (fetch_ready),
      .ctrl_rvalid  (ctrl_rvalid),
      .ctrl_rdata   (ctrl_rdata),
      .req_valid    (fetch_valid),
      .req_kind     (fetch_kind),
      .line_num     (line_num),
      .pal_idx      (pal_idx),
      .run_cnt      (run_cnt),
      .line_done    (line_done)
   );

   scan_addr_gen #(
      .ADDR_W     (ADDR_W),
      .LINE_BYTES (LINE_BYTES),
      .PAL_BYTES  (PAL_BYTES),
      .PAL_SEL_W  (PAL_SEL_W),
      .LINE_W     (LINE_W),
      .CNT_W      (CNT_W),
      .PIX_BASE   (PIX_BASE),
      .CTRL_BASE  (CTRL_BASE),
      .PAL_BASE   (PAL_BASE),
      .PIX_MUL    (PIX_MUL)
   ) addr_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (frame_strobe),
      .line_done    (line_done),
      .req_kind     (fetch_kind),
      .line_num     (line_num),
      .pal_idx      (pal_idx),
      .run_cnt      (run_cnt),
      .addr         (fetch_addr)
   );

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !fetch_ready && !frame_strobe) |=>
      (fetch_valid && $stable(fetch_addr) && $stable(fetch_bank) && $stable(fetch_kind)));

   // R2
   ctrl_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_kind == FK_CTRL) |->
      (fetch_addr >= ADDR_W'(CTRL_BASE) && fetch_addr < ADDR_W'(PAL_BASE)));

   // R3
   pal_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_kind == FK_PAL) |-> (fetch_addr >= ADDR_W'(PAL_BASE)));

   // R4
   pix_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_kind == FK_PIX) |->
      (fetch_addr >= ADDR_W'(PIX_BASE) && fetch_addr < ADDR_W'(CTRL_BASE)));

   // R5
   bank_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && $past(fetch_valid) && !$past(frame_strobe)) |-> $stable(fetch_bank));

   // R10
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_strobe |=> !fetch_valid);

endmodule

// File: tb/scan_fetch_gen_tb_top.sv
module scan_fetch_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_strobe = 1'b0;
   logic        frame_strobe = 1'b0;
   logic [1:0]  page_sel = 2'd0;
   logic        ilace_en = 1'b0;
   logic        fetch_valid;
   logic        fetch_ready = 1'b1;
   logic [7:0]  fetch_bank;
   logic [15:0] fetch_addr;
   logic [1:0]  fetch_kind;
   logic        ctrl_rvalid = 1'b0;
   logic [7:0]  ctrl_rdata = 8'h00;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   scan_fetch_gen dut_i (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .frame_strobe(frame_strobe),
      .page_sel(page_sel), .ilace_en(ilace_en), .fetch_valid(fetch_valid),
      .fetch_ready(fetch_ready), .fetch_bank(fetch_bank), .fetch_addr(fetch_addr),
      .fetch_kind(fetch_kind), .ctrl_rvalid(ctrl_rvalid), .ctrl_rdata(ctrl_rdata)
   );

   typedef struct packed {
      logic [1:0] sel;
      logic       il;
      logic [7:0] cbyte;
      logic [7:0] bank;
   } vec_t;

   // field sequence from reset (odd): expected banks follow R5/R6
   localparam vec_t VEC [10] = '{
      '{2'd0, 1'b0, 8'h05, 8'hE1},
      '{2'd1, 1'b0, 8'hF3, 8'hE0},
      '{2'd2, 1'b0, 8'h0F, 8'hE1},
      '{2'd2, 1'b1, 8'h00, 8'hE0},
      '{2'd2, 1'b1, 8'hA7, 8'hE1},
      '{2'd2, 1'b1, 8'h3C, 8'hE0},
      '{2'd0, 1'b1, 8'h81, 8'hE1},
      '{2'd1, 1'b1, 8'h4E, 8'hE0},
      '{2'd2, 1'b0, 8'hFF, 8'hE1},
      '{2'd3, 1'b0, 8'h19, 8'hE1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_frame();
      @(negedge clk);
      frame_strobe = 1'b1;
      @(negedge clk);
      frame_strobe = 1'b0;
   endtask

   // runs one line and checks every request; inj >= 0 pulses an extra line strobe mid-line
   task automatic do_line(input logic [7:0] cbyte, input logic [7:0] ebank,
                          input int eline, input bit stall, input int inj,
                          input string tag);
      int k = 0;
      int cyc = 0;
      int bad_addr = 0, bad_bank = 0, bad_kind = 0, bad_hold = 0;
      int first_bad_addr = 0, first_exp_addr = 0, seen_bank = ebank;
      bit rv_pend = 0;
      bit held = 0;
      logic [15:0] h_addr = '0;
      logic [7:0]  h_bank = '0;
      int exp_addr;
      int exp_kind;
      ctrl_rdata = cbyte;
      @(negedge clk);
      line_strobe = 1'b1;
      while (k < 193 && cyc < 2000) begin
         @(negedge clk);
         line_strobe = (cyc == inj);
         ctrl_rvalid = rv_pend;
         rv_pend = 0;
         fetch_ready = stall ? ((cyc % 3) != 2) : 1'b1;
         cyc++;
         #1;
         if (fetch_valid) begin
            if (held && (fetch_addr != h_addr || fetch_bank != h_bank)) bad_hold++;
            if (fetch_ready) begin
               if (k == 0) begin
                  exp_kind = 0; exp_addr = 16'h9D00 + eline;
               end else if (k <= 32) begin
                  exp_kind = 1; exp_addr = 16'h9E00 + (cbyte & 8'h0F) * 32 + (k - 1);
               end else begin
                  exp_kind = 2; exp_addr = 16'h2000 + eline * 160 + (k - 33);
               end
               if (int'(fetch_addr) != exp_addr) begin
                  if (bad_addr == 0) begin
                     first_bad_addr = int'(fetch_addr); first_exp_addr = exp_addr;
                  end
                  bad_addr++;
               end
               if (int'(fetch_kind) != exp_kind) bad_kind++;
               if (fetch_bank != ebank) begin bad_bank++; seen_bank = fetch_bank; end
               if (k == 0) rv_pend = 1;
               k++;
               held = 0;
            end else begin
               held = 1; h_addr = fetch_addr; h_bank = fetch_bank;
            end
         end
      end
      @(negedge clk);
      ctrl_rvalid = 1'b0;
      line_strobe = 1'b0;
      fetch_ready = 1'b1;
      #1;
      // R2: full count then valid drops
      chk(k == 193 && !fetch_valid, "R2", {tag, " request count/end"}, k, 193);
      // R2 R3 R4: addresses in order
      chk(bad_addr == 0, "R2/R3/R4", {tag, " address"}, first_bad_addr, first_exp_addr);
      chk(bad_kind == 0, "R2", {tag, " kind"}, bad_kind, 0);
      // R5: bank
      chk(bad_bank == 0, "R5", {tag, " bank"}, seen_bank, ebank);
      if (stall) chk(bad_hold == 0, "R8", {tag, " hold under stall"}, bad_hold, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      chk(!fetch_valid, "R1", "valid after reset", fetch_valid, 0);
      chk(fetch_bank == 8'hE1, "R1", "bank after reset", fetch_bank, 8'hE1);
      do_line(8'h02, 8'hE1, 0, 1'b0, -1, "R1 first line");

      // table walk: settings, frame strobe, one line
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         page_sel = VEC[i].sel;
         ilace_en = VEC[i].il;
         pulse_frame();
         do_line(VEC[i].cbyte, VEC[i].bank, 0, i[0], -1, $sformatf("R6 vec%0d", i));
      end

      // R4: consecutive lines advance
      page_sel = 2'd0; ilace_en = 1'b0;
      pulse_frame();
      do_line(8'h11, 8'hE1, 0, 1'b0, -1, "R4 line0");
      do_line(8'h22, 8'hE1, 1, 1'b1, -1, "R4 line1");
      do_line(8'h33, 8'hE1, 2, 1'b0, -1, "R4 line2");

      // R7: mid-frame change not applied until frame strobe
      page_sel = 2'd1;
      do_line(8'h44, 8'hE1, 3, 1'b0, -1, "R7 mid-frame");
      pulse_frame();
      do_line(8'h44, 8'hE0, 0, 1'b0, -1, "R7 after strobe");

      // R9: strobe injected mid-line is ignored
      do_line(8'h07, 8'hE0, 1, 1'b0, 60, "R9 busy strobe");
      do_line(8'h08, 8'hE0, 2, 1'b0, -1, "R9 next line");

      // R10: frame strobe mid-line aborts
      @(negedge clk); line_strobe = 1'b1; ctrl_rdata = 8'h02;
      @(negedge clk); line_strobe = 1'b0;
      @(negedge clk); ctrl_rvalid = 1'b1;
      @(negedge clk); ctrl_rvalid = 1'b0;
      @(negedge clk);
      #1;
      chk(fetch_valid && fetch_kind == 2'd1, "R10", "in palette before abort", fetch_kind, 1);
      frame_strobe = 1'b1;
      @(negedge clk); frame_strobe = 1'b0;
      #1;
      chk(!fetch_valid, "R10", "valid after abort", fetch_valid, 0);
      do_line(8'h09, 8'hE0, 0, 1'b0, -1, "R10 restart");

      // R9/R4: full frame, then extra strobe ignored
      page_sel = 2'd0;
      pulse_frame();
      for (int n = 0; n < 200; n++) begin
         do_line(8'(n), 8'hE1, n, 1'b0, -1, $sformatf("R4 frame line%0d", n));
      end
      @(negedge clk); line_strobe = 1'b1;
      @(negedge clk); line_strobe = 1'b0;
      begin
         int seen = 0;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            #1;
            if (fetch_valid) seen++;
         end
         chk(seen == 0, "R9", "strobe after 200 lines", seen, 0);
      end
      pulse_frame();
      do_line(8'h0A, 8'hE1, 0, 1'b0, -1, "R9 new frame");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule